// File: doc/BRIEF.md
# Lane-Splittable Registered Adder

This block adds two words of parameterised width (16 bits by default). At run time, its carry chain can be cut so that the same hardware acts as one wide adder, two half-width adders or several narrow adders. The narrow lanes are `SEG_W` bits wide, 4 by default.

The cut points sit at every multiple of `SEG_W` inside the word. Two mode inputs select which cuts are active:

- `fine_en` activates all of them.
- `half_en` activates only the cut at the middle of the word.
- With both low, no cut is active and the word is added as a whole.

Each lane's sum wraps to its own width. The carry out of a lane's top bit is dropped and never enters the lane above.

The combinational sum is captured in an output register on every clock. A synchronous active-high reset clears that register.

Top module: `padd_split_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` is cleared to zero whatever the operands and modes are.
- R2: `sum_q` changes only at a rising clock edge. It shows the result for the operands and modes present at the edge before.
- R3: With `fine_en` = 0 and `half_en` = 0, `sum_q` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R4: With `half_en` = 1 and `fine_en` = 0, bits [WIDTH-1:WIDTH/2] hold the modulo sum of the two upper halves. Bits [WIDTH/2-1:0] hold the modulo sum of the two lower halves.
- R5: With `fine_en` = 1, each `SEG_W`-bit slice [k*SEG_W +: SEG_W] of `sum_q` holds the modulo-2^SEG_W sum of the same slices of the operands.
- R6: When `fine_en` = 1, the value of `half_en` has no effect on the result.
- R7: The carry out of the top bit of any active lane is discarded. For example, 0xFFFF + 0x0001 gives 0xFFF0 in fine mode, 0xFF00 in half mode and 0x0000 with no split.
- R8: The lowest slice, bits [SEG_W-1:0], always equals the low `SEG_W` bits of `op_a` + `op_b`, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| fine_en | input | 1 | Cut the carry at every slice boundary |
| half_en | input | 1 | Cut the carry at the middle of the word |
| sum_q | output | WIDTH | Registered lane sums |

## Verification
Every result is due exactly one rising edge after its operands and mode bits are applied. There is no other latency in the block.

The bench drives new inputs at a falling edge and compares `sum_q` at the next falling edge, against a per-lane masked reference computed for the inputs of the previous step. Just after each new drive, it also checks that `sum_q` still holds the earlier result. This shows that nothing reaches the output before the clock. Mode combinations are covered with fixed carry-heavy patterns and with random operands.

// File: rtl/padd_pkg.sv
package padd_pkg;

  typedef enum logic [1:0] {
    SPLIT_NONE = 2'd0,
    SPLIT_HALF = 2'd1,
    SPLIT_FINE = 2'd2
  } split_e;

endpackage

// File: rtl/padd_break_decode.sv
module padd_break_decode
  import padd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int NPTS = NSEG - 1
) (
  input  logic            fine_en,
  input  logic            half_en,
  output logic [NPTS-1:0] brk
);

  split_e mode;

  // fine mode dominates the half split
  always_comb begin
    if (fine_en)      mode = SPLIT_FINE;
    else if (half_en) mode = SPLIT_HALF;
    else              mode = SPLIT_NONE;
  end

  for (genvar k = 0; k < NPTS; k++) begin : g_pt
    localparam int POS = (k + 1) * SEG_W;
    localparam bit MID = (POS == WIDTH / 2);
    assign brk[k] = (mode == SPLIT_FINE) || ((mode == SPLIT_HALF) && MID);
  end

endmodule

// File: rtl/padd_gap_adder.sv
module padd_gap_adder #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int NPTS = NSEG - 1,
  localparam int EW   = WIDTH + NPTS,
  localparam int STEP = SEG_W + 1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [NPTS-1:0]  brk,
  output logic [WIDTH-1:0] sum,
  output logic [NPTS-1:0]  gap_bits
);

  logic [EW-1:0] xa;
  logic [EW-1:0] xb;
  logic [EW-1:0] xs;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign xa[s*STEP +: SEG_W]  = a[s*SEG_W +: SEG_W];
    assign xb[s*STEP +: SEG_W]  = b[s*SEG_W +: SEG_W];
    assign sum[s*SEG_W +: SEG_W] = xs[s*STEP +: SEG_W];
    if (s < NPTS) begin : g_gap
      // 0+0 absorbs the carry; 1+0 passes it on unchanged
      assign xa[s*STEP + SEG_W] = ~brk[s];
      assign xb[s*STEP + SEG_W] = 1'b0;
      assign gap_bits[s]        = xs[s*STEP + SEG_W];
    end
  end

  assign xs = xa + xb;

endmodule

// File: rtl/padd_split_adder.sv
module padd_split_adder #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4,
  localparam int NSEG = WIDTH / SEG_W,
  localparam int NPTS = NSEG - 1,
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             fine_en,
  input  logic             half_en,
  output logic [WIDTH-1:0] sum_q
);

  logic [NPTS-1:0]  brk;
  logic [NPTS-1:0]  gap_bits;
  logic [WIDTH-1:0] sum_c;

  padd_break_decode #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_dec (
    .fine_en (fine_en),
    .half_en (half_en),
    .brk     (brk)
  );

  padd_gap_adder #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_add (
    .a        (op_a),
    .b        (op_b),
    .brk      (brk),
    .sum      (sum_c),
    .gap_bits (gap_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_c;
  end

  // R1: reset clears the output register
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (sum_q == '0));

  // R3: unsplit word is a plain modulo sum
  a_r3_full_sum: assert property (@(posedge clk) disable iff (rst)
    (!fine_en && !half_en) |=> (sum_q == WIDTH'($past(op_a) + $past(op_b))));

  // R4: half split keeps the upper half independent
  a_r4_upper_half: assert property (@(posedge clk) disable iff (rst)
    (half_en && !fine_en) |=>
      (sum_q[WIDTH-1:HALF] == HALF'($past(op_a[WIDTH-1:HALF]) + $past(op_b[WIDTH-1:HALF]))));

  // R4: half split enables at most one cut
  a_r4_single_break: assert property (@(posedge clk) disable iff (rst)
    !fine_en |-> ($countones(brk) <= 1));

  // R8: lowest slice never depends on mode
  a_r8_low_slice: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sum_q[SEG_W-1:0] == SEG_W'($past(op_a[SEG_W-1:0]) + $past(op_b[SEG_W-1:0]))));

  for (genvar k = 0; k < NSEG; k++) begin : g_chk
    // R5 / R6: each fine slice is its own modulo sum
    a_r5_fine_lane: assert property (@(posedge clk) disable iff (rst)
      fine_en |=> (sum_q[k*SEG_W +: SEG_W] ==
                   SEG_W'($past(op_a[k*SEG_W +: SEG_W]) + $past(op_b[k*SEG_W +: SEG_W]))));
    if (k < NPTS) begin : g_gap
      // R7: in fine mode the trapped gap bit is the lane's own carry out
      a_r7_carry_trapped: assert property (@(posedge clk) disable iff (rst)
        fine_en |-> (gap_bits[k] ==
          ((({1'b0, op_a[k*SEG_W +: SEG_W]} + {1'b0, op_b[k*SEG_W +: SEG_W]}) >> SEG_W) != 0)));
    end
  end

endmodule

// File: tb/padd_split_adder_tb.sv
module padd_split_adder_tb_top;

  localparam int WIDTH = 16;
  localparam int SEG_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             fine_en = 1'b0;
  logic             half_en = 1'b0;
  logic [WIDTH-1:0] sum_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] exp_q = '0;
  logic [WIDTH-1:0] exp_low = '0;
  string exp_tag = "R3";
  bit have_exp = 1'b0;

  always #10 clk = ~clk;

  padd_split_adder #(.WIDTH(WIDTH), .SEG_W(SEG_W)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .fine_en (fine_en),
    .half_en (half_en),
    .sum_q   (sum_q)
  );

  function automatic logic [WIDTH-1:0] ref_sum(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                                              bit f, bit h);
    int w = f ? SEG_W : (h ? WIDTH / 2 : WIDTH);
    longint r = 0;
    for (int lo = 0; lo < WIDTH; lo += w) begin
      longint m = ((longint'(1) << w) - 1) << lo;
      r |= m & ((longint'(a) & m) + (longint'(b) & m));
    end
    return WIDTH'(r);
  endfunction

  task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, expv);
    end
  endtask

  task automatic step(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, bit f, bit h, string tag);
    @(negedge clk);
    if (have_exp) begin
      check(exp_tag, sum_q, exp_q);
      check("R8", sum_q[SEG_W-1:0], exp_low[SEG_W-1:0]);
    end
    op_a = a; op_b = b; fine_en = f; half_en = h;
    #1;
    // R2: output still holds the previous result before the clock
    if (have_exp) check("R2", sum_q, exp_q);
    exp_q = ref_sum(a, b, f, h);
    exp_low = a + b;
    exp_tag = tag;
    have_exp = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    op_a = 16'hFFFF; op_b = 16'h0001; fine_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", sum_q, 16'h0000);
    rst = 1'b0;

    // R7 carry ripple at every lane top
    step(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R7");
    step(16'hFFFF, 16'h0001, 1'b0, 1'b1, "R7");
    step(16'hFFFF, 16'h0001, 1'b1, 1'b0, "R7");
    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R7");
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R7");
    step(16'h0F0F, 16'h0101, 1'b0, 1'b0, "R3");
    step(16'h0000, 16'h0000, 1'b0, 1'b0, "R3");
    step(16'h80FF, 16'h8001, 1'b0, 1'b1, "R4");
    step(16'h1234, 16'hFEDC, 1'b1, 1'b1, "R6");
    step(16'h1234, 16'hFEDC, 1'b1, 1'b0, "R5");
    step(16'h8888, 16'h8888, 1'b1, 1'b1, "R6");

    for (int i = 0; i < 200; i++) begin
      logic [WIDTH-1:0] ra = WIDTH'($urandom);
      logic [WIDTH-1:0] rb = WIDTH'($urandom);
      int md = i % 4;
      case (md)
        0: step(ra, rb, 1'b0, 1'b0, "R3");
        1: step(ra, rb, 1'b0, 1'b1, "R4");
        2: step(ra, rb, 1'b1, 1'b0, "R5");
        default: step(ra, rb, 1'b1, 1'b1, "R6");
      endcase
    end
    step(16'h0000, 16'h0000, 1'b0, 1'b0, "R3");

    // reset mid-run clears again
    @(negedge clk);
    op_a = 16'hAAAA; op_b = 16'h5555; rst = 1'b1;
    @(negedge clk);
    check("R1", sum_q, 16'h0000);
    finish_run();
  end

endmodule